// File: doc/BRIEF.md
# Shared Resource Access Arbiter

The arbiter sits between a host processor and a small coprocessor core. Both use one internal RAM and one slower port that reaches peripheral registers and flash. It runs on a fast clock at twice the host bus rate. A phase bit alternates every fast cycle, so each host bus cycle holds two slots: phase 0 and phase 1. The host is never held back. When the coprocessor collides with the host on the same resource, only the coprocessor waits.

The host presents its request for a whole host bus cycle, and the arbiter uses it in phase 0. The coprocessor may use the RAM in phase 1 at any time. It may also use the RAM in phase 0 when the host leaves it alone, which gives it up to two RAM accesses per host bus cycle. The slow port takes at most one access per host bus cycle, and the host has first claim on it. Each request is split between RAM and the slow port by a single address compare. For each target the arbiter drives a select, an owner bit, a write enable, an address and write data.

Top module: `arb_top`

## Requirements
- R1: While `rstN` is low, `ramSel`, `perSel`, `copReady` and `hostReady` are 0 and `busPhase` is 0. `busPhase` is 0 in the first cycle after reset and toggles on every following cycle.
- R2: In phase 0 a host request is always served. `hostReady` is 1. The addressed target has its select set and its owner bit at 0 (host), and it carries the host address, write enable and data.
- R3: In phase 0, if host and coprocessor both address RAM, the RAM carries the host access and `copReady` is 0.
- R4: In phase 1 a coprocessor RAM request is always granted (`copReady`=1, `ramOwner`=1). A coprocessor RAM request in phase 0 is granted when the host does not address RAM, so two coprocessor RAM accesses can finish in one host bus cycle.
- R5: The slow port is selected at most once per host bus cycle. If the coprocessor used it in phase 0, a coprocessor slow-port request in phase 1 is stalled (`copReady`=0).
- R6: A host slow-port access in phase 0 stalls any coprocessor slow-port request in both phases of that host bus cycle.
- R7: When host and coprocessor address different targets in the same cycle, both are granted in that cycle.
- R8: A host request seen in phase 1 has no effect: no target is selected with owner 0 and `hostReady` is 0.
- R9: A stalled coprocessor request, held stable, is granted in a later cycle once its target is free. `copReady` is 0 in every stalled cycle.
- R10: An address below `PER_BASE` (default 16'h8000) selects RAM. Any other address selects the slow port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast clock, twice the host bus rate |
| rstN | input | 1 | asynchronous active-low reset |
| hostReq | input | 1 | host access request |
| hostWe | input | 1 | host write enable |
| hostAddr | input | AW | host address |
| hostWdata | input | DW | host write data |
| copReq | input | 1 | coprocessor access request, held until ready |
| copWe | input | 1 | coprocessor write enable |
| copAddr | input | AW | coprocessor address |
| copWdata | input | DW | coprocessor write data |
| busPhase | output | 1 | current slot within the host bus cycle |
| hostReady | output | 1 | host access served this cycle |
| copReady | output | 1 | coprocessor access granted this cycle |
| ramSel | output | 1 | RAM access this cycle |
| ramOwner | output | 1 | RAM master: 0 host, 1 coprocessor |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | AW | RAM address |
| ramWdata | output | DW | RAM write data |
| perSel | output | 1 | slow-port access this cycle |
| perOwner | output | 1 | slow-port master: 0 host, 1 coprocessor |
| perWe | output | 1 | slow-port write enable |
| perAddr | output | AW | slow-port address |
| perWdata | output | DW | slow-port write data |

## Verification
Two functions can fall in the same cycle. One is the host's phase-0 claim on a target. The other is the coprocessor's grant, either its double-rate RAM slot or its single slow-port slot. Directed sequences align to a chosen phase and stack these claims: same-RAM conflict, a slow-port grant followed by a phase-1 retry, a host slow-port claim with a waiting coprocessor, and split targets. A long random run keeps the coprocessor request held until ready while the host changes its request each host bus cycle. Every cycle is judged against a reference model in the bench. The model tracks the phase and whether the slow port has been used in the current host bus cycle.

// File: rtl/shared_arb_pkg.sv
package shared_arb_pkg;
  localparam int TGT_N   = 2;
  localparam int TGT_RAM = 0;
  localparam int TGT_PER = 1;

  // strobes from control to datapath, one bit per target
  typedef struct packed {
    logic [TGT_N-1:0] hostGo;
    logic [TGT_N-1:0] copGo;
  } grant_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import shared_arb_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] PER_BASE = 16'h8000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostReq,
  input  logic [AW-1:0] hostAddr,
  input  logic          copReq,
  input  logic [AW-1:0] copAddr,
  output grant_t        go,
  output logic          busPhase,
  output logic          hostReady,
  output logic          copReady
);
  logic phase;
  logic perUsed;
  logic hostSlot;
  logic perFree;
  logic [TGT_N-1:0] hostWant;
  logic [TGT_N-1:0] copWant;

  always_comb begin
    hostSlot          = rstN && hostReq && !phase;
    hostWant[TGT_RAM] = hostSlot && (hostAddr < PER_BASE);
    hostWant[TGT_PER] = hostSlot && !(hostAddr < PER_BASE);
    copWant[TGT_RAM]  = rstN && copReq && (copAddr < PER_BASE);
    copWant[TGT_PER]  = rstN && copReq && !(copAddr < PER_BASE);
    perFree           = !(phase && perUsed);
    go.hostGo         = hostWant;
    go.copGo[TGT_RAM] = copWant[TGT_RAM] && !hostWant[TGT_RAM];
    go.copGo[TGT_PER] = copWant[TGT_PER] && !hostWant[TGT_PER] && perFree;
    copReady          = |go.copGo;
    hostReady         = hostSlot;
    busPhase          = phase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= 1'b0;
      perUsed <= 1'b0;
    end else begin
      phase <= !phase;
      if (!phase) perUsed <= go.hostGo[TGT_PER] || go.copGo[TGT_PER];
      else        perUsed <= 1'b0;
    end
  end
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import shared_arb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  grant_t              go,
  input  logic                hostWe,
  input  logic [AW-1:0]       hostAddr,
  input  logic [DW-1:0]       hostWdata,
  input  logic                copWe,
  input  logic [AW-1:0]       copAddr,
  input  logic [DW-1:0]       copWdata,
  output logic [TGT_N-1:0]    tgtSel,
  output logic [TGT_N-1:0]    tgtOwner,
  output logic [TGT_N-1:0]    tgtWe,
  output logic [TGT_N-1:0][AW-1:0] tgtAddr,
  output logic [TGT_N-1:0][DW-1:0] tgtWdata
);
  for (genvar t = 0; t < TGT_N; t++) begin : g_tgt
    always_comb begin
      tgtSel[t]   = go.hostGo[t] || go.copGo[t];
      tgtOwner[t] = go.copGo[t] && !go.hostGo[t];
      if (go.hostGo[t]) begin
        tgtWe[t]    = hostWe;
        tgtAddr[t]  = hostAddr;
        tgtWdata[t] = hostWdata;
      end else if (go.copGo[t]) begin
        tgtWe[t]    = copWe;
        tgtAddr[t]  = copAddr;
        tgtWdata[t] = copWdata;
      end else begin
        tgtWe[t]    = 1'b0;
        tgtAddr[t]  = '0;
        tgtWdata[t] = '0;
      end
    end
  end
endmodule

// File: rtl/arb_top.sv
module arb_top
  import shared_arb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] PER_BASE = 16'h8000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostReq,
  input  logic          hostWe,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostWdata,
  input  logic          copReq,
  input  logic          copWe,
  input  logic [AW-1:0] copAddr,
  input  logic [DW-1:0] copWdata,
  output logic          busPhase,
  output logic          hostReady,
  output logic          copReady,
  output logic          ramSel,
  output logic          ramOwner,
  output logic          ramWe,
  output logic [AW-1:0] ramAddr,
  output logic [DW-1:0] ramWdata,
  output logic          perSel,
  output logic          perOwner,
  output logic          perWe,
  output logic [AW-1:0] perAddr,
  output logic [DW-1:0] perWdata
);
  grant_t go;
  logic [TGT_N-1:0] tgtSel, tgtOwner, tgtWe;
  logic [TGT_N-1:0][AW-1:0] tgtAddr;
  logic [TGT_N-1:0][DW-1:0] tgtWdata;

  arb_ctrl #(.AW(AW), .PER_BASE(PER_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostAddr(hostAddr),
    .copReq(copReq), .copAddr(copAddr), .go(go), .busPhase(busPhase),
    .hostReady(hostReady), .copReady(copReady)
  );

  arb_datapath #(.AW(AW), .DW(DW)) u_dp (
    .go(go), .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .copWe(copWe), .copAddr(copAddr), .copWdata(copWdata),
    .tgtSel(tgtSel), .tgtOwner(tgtOwner), .tgtWe(tgtWe),
    .tgtAddr(tgtAddr), .tgtWdata(tgtWdata)
  );

  assign ramSel   = tgtSel[TGT_RAM];
  assign ramOwner = tgtOwner[TGT_RAM];
  assign ramWe    = tgtWe[TGT_RAM];
  assign ramAddr  = tgtAddr[TGT_RAM];
  assign ramWdata = tgtWdata[TGT_RAM];
  assign perSel   = tgtSel[TGT_PER];
  assign perOwner = tgtOwner[TGT_PER];
  assign perWe    = tgtWe[TGT_PER];
  assign perAddr  = tgtAddr[TGT_PER];
  assign perWdata = tgtWdata[TGT_PER];
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] PER_BASE = 16'h8000
) (
  input logic          clk,
  input logic          rstN,
  input logic          hostReq,
  input logic [AW-1:0] hostAddr,
  input logic          copReq,
  input logic [AW-1:0] copAddr,
  input logic          busPhase,
  input logic          hostReady,
  input logic          copReady,
  input logic          ramSel,
  input logic          ramOwner,
  input logic          perSel,
  input logic          perOwner
);
  // R2
  host_served_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busPhase && hostReq) |-> hostReady);

  // R3
  ram_conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busPhase && hostReq && hostAddr < PER_BASE && copReq && copAddr < PER_BASE)
      |-> (!copReady && ramSel && !ramOwner));

  // R4
  cop_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busPhase && copReq && copAddr < PER_BASE) |-> (copReady && ramOwner));

  // R5
  per_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busPhase && perSel) |-> !$past(perSel));

  // R8
  host_phase1_chk: assert property (@(posedge clk) disable iff (!rstN)
    busPhase |-> (!hostReady && !(ramSel && !ramOwner) && !(perSel && !perOwner)));

  // R1
  always_comb begin
    if (!rstN) begin
      reset_quiet_chk: assert (!ramSel && !perSel && !copReady && !hostReady);
    end
  end
endmodule

bind arb_top arb_chk #(.AW(AW), .PER_BASE(PER_BASE)) u_chk (.*);

// File: tb/sim_arb_top.sv
module sim_arb_top;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [AW-1:0] PB = 16'h8000;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostReq = 0, hostWe = 0, copReq = 0, copWe = 0;
  logic [AW-1:0] hostAddr = '0, copAddr = '0;
  logic [DW-1:0] hostWdata = '0, copWdata = '0;
  logic busPhase, hostReady, copReady, ramSel, ramOwner, ramWe, perSel, perOwner, perWe;
  logic [AW-1:0] ramAddr, perAddr;
  logic [DW-1:0] ramWdata, perWdata;

  int total = 0, bad = 0;
  bit finished = 0;
  logic mPh = 0, mPu = 0;
  logic lastReady = 0;

  arb_top #(.AW(AW), .DW(DW), .PER_BASE(PB)) u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic hq, input logic hw, input logic [AW-1:0] ha, input logic [DW-1:0] hd,
                      input logic cq, input logic cw, input logic [AW-1:0] ca, input logic [DW-1:0] cd);
    logic hR, hP, cR, cP, cPg;
    @(negedge clk);
    hostReq = hq; hostWe = hw; hostAddr = ha; hostWdata = hd;
    copReq = cq; copWe = cw; copAddr = ca; copWdata = cd;
    #7;
    hR  = hq && !mPh && ha < PB;
    hP  = hq && !mPh && !(ha < PB);
    cR  = cq && ca < PB;
    cP  = cq && !(ca < PB);
    cPg = cP && !hP && !(mPh && mPu);
    chk("R1", "phase", busPhase, mPh);
    chk("R2", "hostReady", hostReady, hq && !mPh);
    chk("R2", "ramSel", ramSel, hR || cR);
    if (hR || cR) begin
      chk("R3", "ramOwner", ramOwner, !hR);
      chk("R2", "ramAddr", ramAddr, hR ? ha : ca);
      chk("R2", "ramWe", ramWe, hR ? hw : cw);
      chk("R2", "ramWdata", ramWdata, hR ? hd : cd);
    end
    chk("R6", "perSel", perSel, hP || cPg);
    if (hP || cPg) chk("R6", "perOwner", perOwner, !hP);
    chk(cP ? "R5" : "R4", "copReady", copReady, (cR && !hR) || cPg);
    lastReady = copReady;
    mPu = mPh ? 1'b0 : (hP || cPg);
    mPh = !mPh;
  endtask

  task automatic idle();
    step(0, 0, '0, '0, 0, 0, '0, '0);
  endtask

  task automatic alignTo(input logic p);
    while (mPh != p) idle();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rams;
    void'($urandom(32'd1234));
    // R1: outputs quiet during reset even with requests present
    hostReq = 1; hostAddr = 16'h0004; copReq = 1; copAddr = 16'h9000;
    repeat (3) @(negedge clk);
    #7;
    chk("R1", "ramSel in reset", ramSel, 0);
    chk("R1", "perSel in reset", perSel, 0);
    chk("R1", "copReady in reset", copReady, 0);
    chk("R1", "phase in reset", busPhase, 0);
    @(negedge clk);
    rstN = 1; hostReq = 0; copReq = 0;
    mPh = 0; mPu = 0;
    #7;
    chk("R1", "first phase", busPhase, 0);
    @(posedge clk);
    mPh = 1;
    idle(); idle();

    // R3 then R9: same-RAM conflict, held request completes in phase 1
    alignTo(0);
    step(1, 1, 16'h0010, 16'hAAAA, 1, 0, 16'h0020, 16'h1111);
    chk("R3", "conflict stall", lastReady, 0);
    chk("R3", "ram carries host", ramAddr, 16'h0010);
    step(1, 1, 16'h0010, 16'hAAAA, 1, 0, 16'h0020, 16'h1111);
    chk("R9", "held request done", lastReady, 1);

    // R4: two coprocessor RAM accesses in one host bus cycle
    alignTo(0);
    rams = 0;
    step(0, 0, '0, '0, 1, 1, 16'h0100, 16'h2222); rams += int'(lastReady);
    step(0, 0, '0, '0, 1, 0, 16'h0102, 16'h3333); rams += int'(lastReady);
    chk("R4", "two ram grants", rams, 2);

    // R5: slow port once per host cycle
    alignTo(0);
    step(0, 0, '0, '0, 1, 0, 16'h8100, '0);
    chk("R5", "first per grant", lastReady, 1);
    step(0, 0, '0, '0, 1, 0, 16'h8102, '0);
    chk("R5", "second per stalled", lastReady, 0);
    step(0, 0, '0, '0, 1, 0, 16'h8102, '0);
    chk("R9", "per retry done", lastReady, 1);

    // R6: host slow-port claim blocks coprocessor for both phases
    alignTo(0);
    step(1, 0, 16'hC000, '0, 1, 1, 16'h8200, 16'h4444);
    chk("R6", "phase0 blocked", lastReady, 0);
    step(1, 0, 16'hC000, '0, 1, 1, 16'h8200, 16'h4444);
    chk("R6", "phase1 blocked", lastReady, 0);
    step(0, 0, '0, '0, 1, 1, 16'h8200, 16'h4444);
    chk("R9", "per after host", lastReady, 1);

    // R7: split targets both proceed
    alignTo(0);
    step(1, 0, 16'hC004, '0, 1, 0, 16'h0040, '0);
    chk("R7", "both selected", {ramSel, perSel, ramOwner, perOwner}, 4'b1110);

    // R8: host request in phase 1 ignored
    alignTo(1);
    step(1, 1, 16'h0050, 16'h5555, 0, 0, '0, '0);
    chk("R8", "host phase1 ram", ramSel, 0);
    chk("R8", "host phase1 ready", hostReady, 0);

    // R10: decode boundary
    alignTo(1);
    step(0, 0, '0, '0, 1, 0, 16'h7FFF, '0);
    chk("R10", "below base is ram", {ramSel, perSel}, 2'b10);
    alignTo(1);
    step(0, 0, '0, '0, 1, 0, 16'h8000, '0);
    chk("R10", "base is per", {ramSel, perSel}, 2'b01);

    // random traffic, coprocessor holds request until ready
    begin
      logic cq = 0, cw = 0, hq = 0, hw = 0;
      logic [AW-1:0] ca = '0, ha = '0;
      logic [DW-1:0] cd = '0, hd = '0;
      for (int i = 0; i < 3000; i++) begin
        if (mPh == 0) begin
          hq = ($urandom % 2) == 0; hw = $urandom % 2;
          ha = AW'($urandom); hd = DW'($urandom);
        end
        if (!cq && ($urandom % 3) != 0) begin
          cq = 1; cw = $urandom % 2; ca = AW'($urandom); cd = DW'($urandom);
        end
        step(hq, hw, ha, hd, cq, cw, ca, cd);
        if (lastReady) cq = 0;
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule